// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a register-style bus port and a flash array. Software drives a small control register and writes into the flash address space. The block checks that the steps of a page erase or a row program arrive in the required order. It also checks that each step arrives only after its minimum settle time, counted in clock cycles set by parameters. Only when both checks pass does it issue a single-cycle erase or program strobe to the array. A protect byte, captured when software reads the protect register, defines a protected region at the top of the address space. A target inside that region is refused.

An erase clears a 64-byte aligned page to all ones. A program operation writes bytes inside one 32-byte aligned row. Only bytes that still read 0xFF may be programmed. If a step comes out of order, comes too early, or comes too late between program bytes, the operation is abandoned. The array is left untouched for that step, and a sticky error flag tells software why. After any finished or abandoned high-voltage operation, the array is unreadable for a recovery interval.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, the control readback is 0x00, `read_ok` is 1, all four error flags are 0, and neither strobe is asserted.
- R2: Control bits are: bit 3 high-voltage enable, bit 2 mass, bit 1 erase, bit 0 program. Readback bits 7..4 are always 0. From idle, only 0x?2 (erase arm) or 0x?1 (program arm) start an operation. Any other nonzero low nibble written in idle sets `err_seq` and leaves the readback at 0.
- R3: Erase order: write 0x02, read the protect register (`bpr_rd`), write any byte inside the target page, wait T_NVS, write 0x0A, wait the erase time, write 0x08, wait T_NVH, write 0x00. The 0x08 write raises `arr_erase` for one cycle, with `arr_addr` equal to the page base (low 6 bits zero). The erase time is T_ERS_LONG when `erase_long` is 1 and T_ERS_SHORT otherwise. A 0x08 write before that time is an early step.
- R4: Program order: write 0x01, read the protect register, dummy-write inside the row, wait T_NVS, write 0x09, wait T_PGS, then write each byte. Each accepted byte raises `arr_pgm` for one cycle, carrying its address and data. Later bytes and the closing 0x08 must each come at least T_PROG cycles after the previous byte. The sequence ends with wait T_NVH, then write 0x00.
- R5: A step taken before its wait time has elapsed abandons the operation without a strobe. It sets `err_seq` and clears the control readback to 0.
- R6: A step that does not match the next expected step abandons the operation in the same way. Examples are a flash write before the protect read, or a control write that is not the next step.
- R7: If neither a byte write nor the closing 0x08 arrives within T_PROG_MAX cycles of the last programmed byte, the operation is abandoned and `err_tprog` is set.
- R8: A program write to a byte whose current value is not 0xFF is abandoned without a strobe, and `err_blank` is set.
- R9: The protected region starts at address {2'b11, BPR, 6'b000000} and runs to 0xFFFF. A BPR of 0xFF protects nothing. A dummy write inside the region sets `err_prot`. After that, writes with the high-voltage bit are ignored, so the readback keeps the arm value. A write of 0x00 returns to idle.
- R10: `read_ok` is 0 from the arming write until T_RCV+1 cycles after the final 0x00 write or after an abandon. It returns to 1 only then.
- R11: A program byte written outside the latched 32-byte row is abandoned with `err_seq` and no strobe.
- R12: Error flags stay set until the next valid arming write, which clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_long | input | 1 | Selects the long minimum erase time |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| bpr_rd | input | 1 | Bus read of the protect register |
| bpr_val | input | 8 | Current protect byte |
| fl_wr | input | 1 | Bus write into flash space |
| fl_addr | input | 16 | Flash write address |
| fl_wdata | input | 8 | Flash write data |
| fl_cur | input | 8 | Current array content at fl_addr |
| arr_pgm | output | 1 | One-cycle byte program strobe |
| arr_erase | output | 1 | One-cycle page erase strobe |
| arr_addr | output | 16 | Array target address for the strobe |
| arr_data | output | 8 | Program data for the strobe |
| read_ok | output | 1 | Array may be read |
| err_seq | output | 1 | Sticky sequence or timing error |
| err_prot | output | 1 | Sticky protect violation |
| err_tprog | output | 1 | Sticky program window overrun |
| err_blank | output | 1 | Sticky write to non-erased byte |

## Verification
A wrong sequencer state shows at the ports within one cycle. Readback bits change, `read_ok` falls or rises at the wrong edge, or a strobe fires where none is due. The cycle-accurate reference model compares all of these on every clock. A wrong wait counter shows as a step that is accepted or refused one cycle off. Steps are therefore placed just past each limit, and early steps are placed well inside it. A wrong latched row, page or protect byte shows on `arr_addr` at the strobe. It also shows afterwards in the array contents, which are read back directly.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_LATCH, ST_BLOCK, ST_NVS,
    ST_ERS, ST_PGS, ST_PROG, ST_NVH, ST_RCV
  } seq_state_t;

  typedef enum logic {OP_ERASE, OP_PGM} seq_op_t;

  localparam int B_HV = 3;
  localparam logic [3:0] C_NONE      = 4'b0000;
  localparam logic [3:0] C_PGM_ARM   = 4'b0001;
  localparam logic [3:0] C_ERASE_ARM = 4'b0010;
  localparam logic [3:0] C_HV_ONLY   = 4'b1000;
endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fseq_prot_cmp.sv
module fseq_prot_cmp #(
  parameter int PAGE_W = 6,
  localparam int ADDR_W = PAGE_W + 10
) (
  input  logic [7:0]        bpr,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] start;
  assign start = {2'b11, bpr, {PAGE_W{1'b0}}};
  assign hit   = (bpr != 8'hFF) && (addr >= start);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int ROW_W       = 5,
  parameter int T_NVS       = 500,
  parameter int T_PGS       = 250,
  parameter int T_NVH       = 250,
  parameter int T_PROG      = 1500,
  parameter int T_PROG_MAX  = 2000,
  parameter int T_ERS_SHORT = 50000,
  parameter int T_ERS_LONG  = 200000,
  parameter int T_RCV       = 50,
  localparam int ADDR_W     = PAGE_W + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_long,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bpr_rd,
  input  logic [7:0]        bpr_val,
  input  logic              fl_wr,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_cur,
  output logic              arr_pgm,
  output logic              arr_erase,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              read_ok,
  output logic              err_seq,
  output logic              err_prot,
  output logic              err_tprog,
  output logic              err_blank
);
  localparam int T_A   = (T_NVS > T_PGS) ? T_NVS : T_PGS;
  localparam int T_B   = (T_NVH > T_RCV) ? T_NVH : T_RCV;
  localparam int T_C   = (T_PROG_MAX > T_ERS_SHORT) ? T_PROG_MAX : T_ERS_SHORT;
  localparam int T_D   = (T_ERS_LONG > T_PROG) ? T_ERS_LONG : T_PROG;
  localparam int T_AB  = (T_A > T_B) ? T_A : T_B;
  localparam int T_CD  = (T_C > T_D) ? T_C : T_D;
  localparam int T_MAX = (T_AB > T_CD) ? T_AB : T_CD;
  localparam int CNT_W = $clog2(T_MAX + 2);

  localparam logic [CNT_W-1:0] L_NVS  = CNT_W'(T_NVS);
  localparam logic [CNT_W-1:0] L_PGS  = CNT_W'(T_PGS);
  localparam logic [CNT_W-1:0] L_NVH  = CNT_W'(T_NVH);
  localparam logic [CNT_W-1:0] L_PROG = CNT_W'(T_PROG);
  localparam logic [CNT_W-1:0] L_PMAX = CNT_W'(T_PROG_MAX);
  localparam logic [CNT_W-1:0] L_ERSS = CNT_W'(T_ERS_SHORT);
  localparam logic [CNT_W-1:0] L_ERSL = CNT_W'(T_ERS_LONG);
  localparam logic [CNT_W-1:0] L_RCV  = CNT_W'(T_RCV);

  seq_state_t        st_q, st_d;
  seq_op_t           op_q, op_d;
  logic [3:0]        ctrl_q, ctrl_d;
  logic [7:0]        bpr_q, bpr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  ers_lim;
  logic [3:0]        wr_lo;
  logic              unused_wr_hi;
  logic              tgt_hit, lat_hit, in_row;
  logic              abort, ab_tprog, ab_blank, set_seq, set_prot, clr_err;
  logic              do_pgm, do_ers, byte_acc, tmr_clr;

  assign wr_lo        = reg_wdata[3:0];
  assign unused_wr_hi = ^reg_wdata[7:4];
  assign ers_lim      = erase_long ? L_ERSL : L_ERSS;
  assign in_row       = fl_addr[ADDR_W-1:ROW_W] == base_q[ADDR_W-1:ROW_W];

  fseq_prot_cmp #(.PAGE_W(PAGE_W)) u_tgt_cmp (
    .bpr(bpr_q), .addr(fl_addr), .hit(tgt_hit)
  );
  fseq_prot_cmp #(.PAGE_W(PAGE_W)) u_lat_cmp (
    .bpr(bpr_q), .addr(base_q), .hit(lat_hit)
  );

  assign tmr_clr = (st_d != st_q) || byte_acc;
  fseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(cnt)
  );

  always_comb begin
    st_d = st_q; op_d = op_q; ctrl_d = ctrl_q; bpr_d = bpr_q; base_d = base_q;
    abort = 1'b0; ab_tprog = 1'b0; ab_blank = 1'b0;
    set_seq = 1'b0; set_prot = 1'b0; clr_err = 1'b0;
    do_pgm = 1'b0; do_ers = 1'b0; byte_acc = 1'b0;
    unique case (st_q)
      ST_IDLE: if (reg_wr) begin
        if (wr_lo == C_ERASE_ARM) begin
          op_d = OP_ERASE; ctrl_d = wr_lo; st_d = ST_ARM; clr_err = 1'b1;
        end else if (wr_lo == C_PGM_ARM) begin
          op_d = OP_PGM; ctrl_d = wr_lo; st_d = ST_ARM; clr_err = 1'b1;
        end else if (wr_lo != C_NONE) begin
          set_seq = 1'b1;
        end
      end
      ST_ARM: begin
        if (reg_wr || fl_wr) abort = 1'b1;
        else if (bpr_rd) begin
          bpr_d = bpr_val; st_d = ST_LATCH;
        end
      end
      ST_LATCH: begin
        if (reg_wr) abort = 1'b1;
        else if (fl_wr) begin
          base_d = (op_q == OP_PGM) ? {fl_addr[ADDR_W-1:ROW_W], {ROW_W{1'b0}}}
                                    : {fl_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
          if (tgt_hit) begin
            set_prot = 1'b1; st_d = ST_BLOCK;
          end else begin
            st_d = ST_NVS;
          end
        end
      end
      ST_BLOCK: if (reg_wr && wr_lo == C_NONE) begin
        ctrl_d = C_NONE; st_d = ST_IDLE;
      end
      ST_NVS: begin
        if (reg_wr) begin
          if (wr_lo == (ctrl_q | C_HV_ONLY) && cnt >= L_NVS) begin
            ctrl_d = wr_lo;
            st_d   = (op_q == OP_PGM) ? ST_PGS : ST_ERS;
          end else abort = 1'b1;
        end else if (fl_wr) abort = 1'b1;
      end
      ST_ERS: begin
        if (reg_wr) begin
          if (wr_lo == C_HV_ONLY && cnt >= ers_lim) begin
            ctrl_d = C_HV_ONLY; do_ers = 1'b1; st_d = ST_NVH;
          end else abort = 1'b1;
        end else if (fl_wr) abort = 1'b1;
      end
      ST_PGS, ST_PROG: begin
        if (reg_wr) begin
          if (st_q == ST_PROG && wr_lo == C_HV_ONLY && cnt >= L_PROG) begin
            ctrl_d = C_HV_ONLY; st_d = ST_NVH;
          end else abort = 1'b1;
        end else if (fl_wr) begin
          if (!in_row || cnt < ((st_q == ST_PGS) ? L_PGS : L_PROG)) abort = 1'b1;
          else if (fl_cur != 8'hFF) begin
            abort = 1'b1; ab_blank = 1'b1;
          end else begin
            do_pgm = 1'b1; byte_acc = 1'b1; st_d = ST_PROG;
          end
        end else if (st_q == ST_PROG && cnt >= L_PMAX) begin
          abort = 1'b1; ab_tprog = 1'b1;
        end
      end
      ST_NVH: begin
        if (reg_wr) begin
          if (wr_lo == C_NONE && cnt >= L_NVH) begin
            ctrl_d = C_NONE; st_d = ST_RCV;
          end else abort = 1'b1;
        end else if (fl_wr) abort = 1'b1;
      end
      ST_RCV: if (cnt >= L_RCV) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      ctrl_d = C_NONE; st_d = ST_RCV;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; op_q <= OP_ERASE; ctrl_q <= '0; bpr_q <= 8'hFF; base_q <= '0;
      arr_pgm <= 1'b0; arr_erase <= 1'b0; arr_addr <= '0; arr_data <= '0;
      read_ok <= 1'b1;
      err_seq <= 1'b0; err_prot <= 1'b0; err_tprog <= 1'b0; err_blank <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; ctrl_q <= ctrl_d; bpr_q <= bpr_d; base_q <= base_d;
      arr_pgm   <= do_pgm;
      arr_erase <= do_ers;
      if (do_pgm) begin
        arr_addr <= fl_addr; arr_data <= fl_wdata;
      end else if (do_ers) begin
        arr_addr <= base_q;
      end
      read_ok <= (st_d == ST_IDLE);
      if (clr_err) begin
        err_seq <= 1'b0; err_prot <= 1'b0; err_tprog <= 1'b0; err_blank <= 1'b0;
      end else begin
        err_seq   <= err_seq | set_seq | (abort & ~ab_tprog & ~ab_blank);
        err_prot  <= err_prot | set_prot;
        err_tprog <= err_tprog | ab_tprog;
        err_blank <= err_blank | ab_blank;
      end
    end
  end

  assign reg_rdata = {4'b0000, ctrl_q};

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(arr_pgm && arr_erase));
  assert_erase_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    arr_erase |-> (arr_addr[PAGE_W-1:0] == '0));
  assert_pgm_in_row_R11: assert property (@(posedge clk) disable iff (rst)
    arr_pgm |-> (arr_addr[ADDR_W-1:ROW_W] == base_q[ADDR_W-1:ROW_W]));
  assert_no_protected_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (arr_pgm || arr_erase) |-> !lat_hit);
  assert_hv_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BLOCK) |-> !ctrl_q[B_HV]);
  assert_busy_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (arr_pgm || arr_erase) |-> !read_ok);
  assert_abort_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_seq) |-> (reg_rdata[3:0] == 4'b0000));
  assert_tprog_abort_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_tprog) |-> (reg_rdata == 8'h00 && !read_ok && !arr_pgm));
endmodule

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
  localparam int T_NVS = 4, T_PGS = 3, T_NVH = 3, T_PROG = 5, T_PMAX = 12;
  localparam int T_ERSS = 20, T_ERSL = 40, T_RCV = 2;
  localparam int MI = 0, MA = 1, ML = 2, MB = 3, MN = 4, ME = 5, MP = 6, MR = 7, MH = 8, MC = 9;

  logic clk = 1'b0, rst = 1'b1, erase_long = 1'b0;
  logic reg_wr = 1'b0, bpr_rd = 1'b0, fl_wr = 1'b0;
  logic [7:0] reg_wdata = '0, bpr_val = 8'hFF, fl_wdata = '0, fl_cur;
  logic [15:0] fl_addr = '0;
  logic [7:0] reg_rdata, arr_data;
  logic [15:0] arr_addr;
  logic arr_pgm, arr_erase, read_ok, err_seq, err_prot, err_tprog, err_blank;

  logic [7:0] mem [0:4095];
  int vec = 0, fail = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  flash_seq_ctrl #(
    .T_NVS(T_NVS), .T_PGS(T_PGS), .T_NVH(T_NVH), .T_PROG(T_PROG), .T_PROG_MAX(T_PMAX),
    .T_ERS_SHORT(T_ERSS), .T_ERS_LONG(T_ERSL), .T_RCV(T_RCV)
  ) u0 (
    .clk(clk), .rst(rst), .erase_long(erase_long), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bpr_rd(bpr_rd), .bpr_val(bpr_val), .fl_wr(fl_wr),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_cur(fl_cur), .arr_pgm(arr_pgm),
    .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_data(arr_data), .read_ok(read_ok),
    .err_seq(err_seq), .err_prot(err_prot), .err_tprog(err_tprog), .err_blank(err_blank)
  );

  // behavioural flash array: top 4 KB of the address space
  initial for (int i = 0; i < 4096; i++) mem[i] = 8'h5A;
  assign fl_cur = mem[fl_addr[11:0]];
  always @(posedge clk) begin
    if (arr_pgm) mem[arr_addr[11:0]] <= mem[arr_addr[11:0]] & arr_data;
    if (arr_erase) for (int i = 0; i < 64; i++) mem[{arr_addr[11:6], 6'(i)}] <= 8'hFF;
  end

  // reference model
  int m_st = MI, m_tmr = 0, m_base = 0, m_bpr = 255, m_a = 0, m_d = 0;
  bit m_op_pgm = 0, m_pgm = 0, m_ers = 0, e_seq = 0, e_prot = 0, e_tp = 0, e_bl = 0;
  logic [3:0] m_ctrl = 0;
  bit started = 0;

  function automatic bit prot_hit(int bpr, int addr);
    if (bpr == 255) return 0;
    return addr >= (49152 + bpr * 64);
  endfunction

  always @(posedge clk) begin
    int prev, lo, a, lim;
    bit ab, abk_t, abk_b, acc;
    started = 1;
    if (rst) begin
      m_st = MI; m_tmr = 0; m_ctrl = 0; m_pgm = 0; m_ers = 0; m_bpr = 255; m_base = 0;
      e_seq = 0; e_prot = 0; e_tp = 0; e_bl = 0;
    end else begin
      prev = m_st; lo = int'(reg_wdata[3:0]); a = int'(fl_addr);
      ab = 0; abk_t = 0; abk_b = 0; acc = 0; m_pgm = 0; m_ers = 0;
      case (m_st)
        MI: if (reg_wr) begin
          if (lo == 2 || lo == 1) begin
            m_op_pgm = (lo == 1); m_ctrl = 4'(lo); m_st = MA;
            e_seq = 0; e_prot = 0; e_tp = 0; e_bl = 0;
          end else if (lo != 0) e_seq = 1;
        end
        MA: if (reg_wr || fl_wr) ab = 1; else if (bpr_rd) begin m_bpr = int'(bpr_val); m_st = ML; end
        ML: if (reg_wr) ab = 1; else if (fl_wr) begin
          m_base = m_op_pgm ? (a / 32) * 32 : (a / 64) * 64;
          if (prot_hit(m_bpr, a)) begin e_prot = 1; m_st = MB; end else m_st = MN;
        end
        MB: if (reg_wr && lo == 0) begin m_ctrl = 0; m_st = MI; end
        MN: if (reg_wr) begin
          if (lo == (int'(m_ctrl) + 8) && m_tmr >= T_NVS) begin
            m_ctrl = 4'(lo); m_st = m_op_pgm ? MP : ME;
          end else ab = 1;
        end else if (fl_wr) ab = 1;
        ME: begin
          lim = erase_long ? T_ERSL : T_ERSS;
          if (reg_wr) begin
            if (lo == 8 && m_tmr >= lim) begin
              m_ctrl = 8; m_ers = 1; m_a = m_base; m_st = MH;
            end else ab = 1;
          end else if (fl_wr) ab = 1;
        end
        MP, MR: begin
          lim = (m_st == MP) ? T_PGS : T_PROG;
          if (reg_wr) begin
            if (m_st == MR && lo == 8 && m_tmr >= T_PROG) begin m_ctrl = 8; m_st = MH; end
            else ab = 1;
          end else if (fl_wr) begin
            if ((a / 32) != (m_base / 32) || m_tmr < lim) ab = 1;
            else if (fl_cur != 8'hFF) begin ab = 1; abk_b = 1; end
            else begin m_pgm = 1; m_a = a; m_d = int'(fl_wdata); acc = 1; m_st = MR; end
          end else if (m_st == MR && m_tmr >= T_PMAX) begin ab = 1; abk_t = 1; end
        end
        MH: if (reg_wr) begin
          if (lo == 0 && m_tmr >= T_NVH) begin m_ctrl = 0; m_st = MC; end else ab = 1;
        end else if (fl_wr) ab = 1;
        MC: if (m_tmr >= T_RCV) m_st = MI;
        default: m_st = MI;
      endcase
      if (ab) begin
        m_ctrl = 0; m_st = MC;
        if (abk_t) e_tp = 1; else if (abk_b) e_bl = 1; else e_seq = 1;
      end
      if (m_st != prev || acc) m_tmr = 0; else m_tmr++;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) if (started) begin
    logic [36:0] act, exp_v;
    act   = {reg_rdata, read_ok, err_seq, err_prot, err_tprog, err_blank, arr_pgm, arr_erase,
             (arr_pgm || arr_erase) ? arr_addr : 16'h0, arr_pgm ? arr_data : 8'h0};
    exp_v = {4'h0, m_ctrl, (m_st == MI), e_seq, e_prot, e_tp, e_bl, m_pgm, m_ers,
             (m_pgm || m_ers) ? 16'(m_a) : 16'h0, m_pgm ? 8'(m_d) : 8'h0};
    vec++;
    if (act !== exp_v) begin
      fail++;
      $display("FAIL %s at %0t: actual %h expected %h", cur_req, $time, act, exp_v);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    vec++;
    if (act !== exp_v) begin
      fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic ctrl_w(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic fl_w(input logic [15:0] ad, input logic [7:0] d);
    @(negedge clk); fl_wr = 1'b1; fl_addr = ad; fl_wdata = d;
    @(negedge clk); fl_wr = 1'b0;
  endtask
  task automatic bpr_read();
    @(negedge clk); bpr_rd = 1'b1;
    @(negedge clk); bpr_rd = 1'b0;
  endtask
  task automatic prog_open(input logic [15:0] dummy);
    ctrl_w(8'h01); bpr_read(); fl_w(dummy, 8'h00); idle(T_NVS); ctrl_w(8'h09); idle(T_PGS);
  endtask
  task automatic prog_close();
    ctrl_w(8'h08); idle(T_NVH); ctrl_w(8'h00); idle(T_RCV + 2);
  endtask
  task automatic erase_run(input logic [15:0] ad, input int wait_ers);
    ctrl_w(8'h02); bpr_read(); fl_w(ad, 8'h77); idle(T_NVS); ctrl_w(8'h0A);
    idle(wait_ers); ctrl_w(8'h08);
  endtask
  task automatic erase_tail();
    idle(T_NVH); ctrl_w(8'h00); idle(T_RCV + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    cur_req = "R1";
    chk("R1 readback", {24'h0, reg_rdata}, 32'h0);
    chk("R1 read_ok", {31'h0, read_ok}, 32'h1);
    chk("R1 errors", {28'h0, err_seq, err_prot, err_tprog, err_blank}, 32'h0);

    cur_req = "R3";
    bpr_val = 8'hFF;
    ctrl_w(8'hF2);
    chk("R2 upper bits zero", {24'h0, reg_rdata}, 32'h02);
    chk("R10 busy after arm", {31'h0, read_ok}, 32'h0);
    bpr_read(); fl_w(16'hF050, 8'h77); idle(T_NVS); ctrl_w(8'h0A); idle(T_ERSS); ctrl_w(8'h08);
    erase_tail();
    chk("R3 page erased low", {24'h0, mem[12'h040]}, 32'hFF);
    chk("R3 page erased high", {24'h0, mem[12'h07F]}, 32'hFF);
    chk("R3 below page kept", {24'h0, mem[12'h03F]}, 32'h5A);
    chk("R3 above page kept", {24'h0, mem[12'h080]}, 32'h5A);
    chk("R10 readable after recovery", {31'h0, read_ok}, 32'h1);

    cur_req = "R2";
    ctrl_w(8'h06);
    chk("R2 bad arm sets err_seq", {31'h0, err_seq}, 32'h1);
    chk("R2 bad arm readback", {24'h0, reg_rdata}, 32'h0);

    cur_req = "R4";
    prog_open(16'hF040);
    fl_w(16'hF041, 8'h3C); idle(T_PROG); fl_w(16'hF05F, 8'hC3); idle(T_PROG);
    prog_close();
    chk("R4 byte one", {24'h0, mem[12'h041]}, 32'h3C);
    chk("R4 byte two", {24'h0, mem[12'h05F]}, 32'hC3);
    chk("R4 neighbour blank", {24'h0, mem[12'h042]}, 32'hFF);
    chk("R12 errors cleared by start", {28'h0, err_seq, err_prot, err_tprog, err_blank}, 32'h0);

    cur_req = "R8";
    prog_open(16'hF040);
    fl_w(16'hF041, 8'h00);
    chk("R8 err_blank", {31'h0, err_blank}, 32'h1);
    idle(T_RCV + 2);
    chk("R8 byte unchanged", {24'h0, mem[12'h041]}, 32'h3C);

    cur_req = "R6";
    ctrl_w(8'h01);
    chk("R12 flags cleared on arm", {28'h0, err_seq, err_prot, err_tprog, err_blank}, 32'h0);
    fl_w(16'hF040, 8'h00);
    chk("R6 write before protect read", {31'h0, err_seq}, 32'h1);
    idle(T_RCV + 2);

    cur_req = "R5";
    ctrl_w(8'h02); bpr_read(); fl_w(16'hF080, 8'h00); ctrl_w(8'h0A);
    chk("R5 early hv sets err_seq", {31'h0, err_seq}, 32'h1);
    chk("R5 readback cleared", {24'h0, reg_rdata}, 32'h0);
    idle(T_RCV + 2);
    chk("R5 array untouched", {24'h0, mem[12'h080]}, 32'h5A);

    cur_req = "R11";
    prog_open(16'hF060);
    fl_w(16'hF043, 8'h00);
    chk("R11 out of row err_seq", {31'h0, err_seq}, 32'h1);
    idle(T_RCV + 2);
    chk("R11 byte untouched", {24'h0, mem[12'h043]}, 32'hFF);

    cur_req = "R7";
    prog_open(16'hF060);
    fl_w(16'hF061, 8'h11); idle(T_PMAX + 3);
    chk("R7 err_tprog", {31'h0, err_tprog}, 32'h1);
    chk("R7 readback cleared", {24'h0, reg_rdata}, 32'h0);
    chk("R7 first byte written", {24'h0, mem[12'h061]}, 32'h11);

    cur_req = "R9";
    bpr_val = 8'hFD;
    ctrl_w(8'h01); bpr_read(); fl_w(16'hFF40, 8'h00);
    chk("R9 protected target", {31'h0, err_prot}, 32'h1);
    idle(T_NVS); ctrl_w(8'h09);
    chk("R9 hv ignored", {24'h0, reg_rdata}, 32'h01);
    ctrl_w(8'h00);
    chk("R9 clear returns idle", {31'h0, read_ok}, 32'h1);
    erase_run(16'hF0C0, T_ERSS); erase_tail();
    chk("R9 below start unprotected", {31'h0, err_prot}, 32'h0);
    chk("R9 erase below start", {24'h0, mem[12'h0C0]}, 32'hFF);
    bpr_val = 8'h00;
    ctrl_w(8'h02); bpr_read(); fl_w(16'hF100, 8'h00);
    chk("R9 low byte protects all", {31'h0, err_prot}, 32'h1);
    ctrl_w(8'h00);
    bpr_val = 8'hFF;

    cur_req = "R3";
    erase_long = 1'b1;
    erase_run(16'hF100, T_ERSS);
    chk("R3 long erase early clear", {31'h0, err_seq}, 32'h1);
    idle(T_RCV + 2);
    chk("R3 early clear untouched", {24'h0, mem[12'h100]}, 32'h5A);
    erase_run(16'hF100, T_ERSL); erase_tail();
    chk("R3 long erase done", {24'h0, mem[12'h13F]}, 32'hFF);
    chk("R3 long erase no error", {31'h0, err_seq}, 32'h0);

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end
endmodule